// File: doc/BRIEF.md
# Flash Protected Range Guard

This block decides whether a pending flash access may go ahead. It holds a small bank of protection windows. Each window is one 32-bit word that gives a first and a last 4 KB page. Each window also has one enable that protects it against reads and a separate enable that protects it against modification. A window covers every byte from its first page up to the end of its last page. The last page is included, so the low 12 address bits of the upper bound are taken as all ones.

The flash sequencer presents each access as a start address, a byte count and a kind. The kind is one of read, program, 4 KB block erase or 64 KB block erase. One cycle later the block returns a single deny flag, which the sequencer turns into an access-error status. A program access or an erase is checked only against write-protected windows. A read is checked only against read-protected windows. An erase is checked over its whole aligned block, not only over the address that was given.

The windows are written through a simple select/data port and can be read back through a second select. While the controller's lock-down input is high, writes to the windows are discarded.

Top module: `prot_range_guard`

## Requirements
- R1: Window word layout: first page in bits 13:0, read-protect enable in bit 15, last page in bits 29:16, write-protect enable in bit 31. Bits 14 and 30 are not stored and read back as 0. The read port returns the stored word of the selected window, and returns 0 for a select at or above the window count.
- R2: After reset every window word is zero and no access is denied.
- R3: A window covers the bytes from first_page*4096 to last_page*4096+4095, both ends included. A read (kind 2'b00) that touches any byte of an enabled read-protected window is denied. A read entirely outside every such window is allowed.
- R4: A program access (kind 2'b01) is denied when it touches an enabled write-protected window. Read protection alone never denies a program access or an erase, and write protection alone never denies a read.
- R5: A window with both enables clear has no effect on any access.
- R6: For reads and program accesses the span runs from acc_addr to acc_addr+acc_cnt, where acc_cnt is the byte count minus one (up to 64 bytes). An access that crosses a page boundary into a window is denied.
- R7: A 4 KB erase (kind 2'b10) is checked over the aligned 4 KB block that holds acc_addr. A 64 KB erase (kind 2'b11) is checked over the aligned 64 KB block that holds acc_addr. Both are checked against write protection.
- R8: A window whose first page is above its last page covers nothing, even for an access that spans both pages.
- R9: While freeze is high, window writes are discarded. A write whose select is at or above the window count is also discarded.
- R10: res_valid is high exactly one cycle after a cycle with acc_valid high. res_deny is never high while res_valid is low.
- R11: Any window can deny, whatever its index. The result is the OR over all windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for a window word |
| reg_wr_sel | input | SEL_W | Window index to write |
| reg_wr_data | input | 32 | Window word to write |
| reg_rd_sel | input | SEL_W | Window index to read back |
| reg_rd_data | output | 32 | Stored word of the selected window |
| freeze | input | 1 | Lock-down flag; discards window writes while high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 read, 01 program, 10 4 KB erase, 11 64 KB erase |
| acc_addr | input | ADDR_W | Byte start address of the access |
| acc_cnt | input | CNT_W | Byte count minus one, for read and program |
| res_valid | output | 1 | Result of the access presented one cycle earlier |
| res_deny | output | 1 | The access touches a protected window |

## Verification
The case that is hardest to reach is an access whose two ends compare correctly against a window's two bounds while the window itself is empty. This happens when the first page is above the last page and the access spans both of those pages. The bench programs one window that way and sends a short program access that crosses exactly that page boundary. A naive overlap test would deny it, and the bench expects it to be allowed. Other stimulus goes for the inclusive ends: the last byte of the last page, and the byte just past it. It also sends accesses that wrap through a page carry, and 64 KB erases whose given address lies outside the window while the aligned block overlaps it.

// File: rtl/prg_pkg.sv
package prg_pkg;

   localparam int PG_W = 14;

   typedef enum logic [1:0] {
      ACC_READ      = 2'b00,
      ACC_PROGRAM   = 2'b01,
      ACC_ERASE_4K  = 2'b10,
      ACC_ERASE_64K = 2'b11
   } acc_kind_e;

   typedef struct packed {
      logic            wr_guard;
      logic [PG_W-1:0] last_pg;
      logic            rd_guard;
      logic [PG_W-1:0] first_pg;
   } win_t;

   function automatic logic [31:0] win_to_word(win_t w);
      return {w.wr_guard, 1'b0, w.last_pg, w.rd_guard, 1'b0, w.first_pg};
   endfunction

endpackage

// File: rtl/prg_span.sv
module prg_span
   import prg_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int CNT_W  = 6
) (
   input  logic [1:0]        kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cnt,
   output logic [PG_W:0]     span_lo,
   output logic [PG_W:0]     span_hi,
   output logic              modify
);

   localparam int APG_W = ADDR_W - 12;

   if (ADDR_W < 16 || ADDR_W > PG_W + 12) begin : g_bad_addr
      $error("prg_span: ADDR_W must lie in 16..26");
   end
   if (CNT_W < 1 || CNT_W > 12) begin : g_bad_cnt
      $error("prg_span: CNT_W must lie in 1..12");
   end

   logic [12:0]    off_sum;
   logic [PG_W:0]  addr_pg;
   logic           unused_off;

   assign off_sum    = {1'b0, addr[11:0]} + 13'(cnt);
   assign unused_off = ^off_sum[11:0];
   assign addr_pg    = (PG_W+1)'(addr[ADDR_W-1:12]);
   assign modify     = (kind != ACC_READ);

   always_comb begin
      span_lo = addr_pg;
      span_hi = addr_pg;
      case (acc_kind_e'(kind))
         ACC_READ, ACC_PROGRAM: begin
            span_lo = addr_pg;
            span_hi = addr_pg + (PG_W+1)'(off_sum[12]);
         end
         ACC_ERASE_4K: begin
            span_lo = addr_pg;
            span_hi = addr_pg;
         end
         ACC_ERASE_64K: begin
            span_lo = {addr_pg[PG_W:4], 4'h0};
            span_hi = {addr_pg[PG_W:4], 4'hF};
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/prg_bank.sv
module prg_bank
   import prg_pkg::*;
#(
   parameter int N_WIN = 6,
   parameter int SEL_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [31:0]           wr_data,
   input  logic                  freeze,
   input  logic [SEL_W-1:0]      rd_sel,
   output logic [31:0]           rd_data,
   output win_t [N_WIN-1:0]      wins
);

   localparam logic [31:0] KEEP_MASK = 32'hBFFF_BFFF;

   if (N_WIN < 1 || (1 << SEL_W) < N_WIN) begin : g_bad_sel
      $error("prg_bank: SEL_W too narrow for N_WIN");
   end

   win_t [N_WIN-1:0] store;
   win_t             wr_word;
   logic             unused_gap;

   assign wr_word = '{wr_guard: wr_data[31], last_pg: wr_data[29:16],
                      rd_guard: wr_data[15], first_pg: wr_data[13:0]};
   assign unused_gap = wr_data[30] ^ wr_data[14];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store <= '0;
      end else begin
         for (int i = 0; i < N_WIN; i++) begin
            if (wr_en && !freeze && wr_sel == SEL_W'(i))
               store[i] <= wr_word;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_WIN; i++) begin
         if (rd_sel == SEL_W'(i))
            rd_data = win_to_word(store[i]);
      end
   end

   assign wins = store;

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && freeze) |=> $stable(store)); // R9
   AST_BAD_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_sel) >= N_WIN) |=> $stable(store)); // R9
   AST_WORD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !freeze && int'(wr_sel) < N_WIN) |=>
      (win_to_word(store[$past(wr_sel)]) == ($past(wr_data) & KEEP_MASK))); // R1

endmodule

// File: rtl/prg_slot.sv
module prg_slot
   import prg_pkg::*;
(
   input  win_t          win,
   input  logic [PG_W:0] span_lo,
   input  logic [PG_W:0] span_hi,
   input  logic          modify,
   output logic          hit
);

   logic guarded;
   logic well_formed;
   logic overlap;

   assign guarded     = modify ? win.wr_guard : win.rd_guard;
   assign well_formed = (win.first_pg <= win.last_pg);
   assign overlap     = (span_lo <= {1'b0, win.last_pg}) &&
                        (span_hi >= {1'b0, win.first_pg});
   assign hit         = guarded && well_formed && overlap;

endmodule

// File: rtl/prot_range_guard.sv
module prot_range_guard
   import prg_pkg::*;
#(
   parameter int N_WIN   = 6,
   parameter int ADDR_W  = 26,
   parameter int CNT_W   = 6,
   parameter bit REG_OUT = 1'b1,
   localparam int SEL_W  = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [SEL_W-1:0]  reg_wr_sel,
   input  logic [31:0]       reg_wr_data,
   input  logic [SEL_W-1:0]  reg_rd_sel,
   output logic [31:0]       reg_rd_data,
   input  logic              freeze,
   input  logic              acc_valid,
   input  logic [1:0]        acc_kind,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [CNT_W-1:0]  acc_cnt,
   output logic              res_valid,
   output logic              res_deny
);

   if (N_WIN < 1 || N_WIN > 16) begin : g_bad_count
      $error("prot_range_guard: N_WIN must lie in 1..16");
   end

   win_t [N_WIN-1:0] wins;
   logic [PG_W:0]    span_lo;
   logic [PG_W:0]    span_hi;
   logic             modify;
   logic [N_WIN-1:0] hit_vec;
   logic             deny_now;

   prg_bank #(.N_WIN(N_WIN), .SEL_W(SEL_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_sel  (reg_wr_sel),
      .wr_data (reg_wr_data),
      .freeze  (freeze),
      .rd_sel  (reg_rd_sel),
      .rd_data (reg_rd_data),
      .wins    (wins)
   );

   prg_span #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_span (
      .kind    (acc_kind),
      .addr    (acc_addr),
      .cnt     (acc_cnt),
      .span_lo (span_lo),
      .span_hi (span_hi),
      .modify  (modify)
   );

   for (genvar g = 0; g < N_WIN; g++) begin : g_slot
      prg_slot u_slot (
         .win     (wins[g]),
         .span_lo (span_lo),
         .span_hi (span_hi),
         .modify  (modify),
         .hit     (hit_vec[g])
      );
   end

   assign deny_now = acc_valid && (|hit_vec);

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_valid <= 1'b0;
            res_deny  <= 1'b0;
         end else begin
            res_valid <= acc_valid;
            res_deny  <= deny_now;
         end
      end

      AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid |=> res_valid); // R10
      AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_valid |=> !res_valid); // R10
      AST_DENY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
         res_deny |-> res_valid); // R10
   end else begin : g_comb_out
      assign res_valid = acc_valid;
      assign res_deny  = deny_now;
   end

   AST_SPAN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (span_hi >= span_lo)); // R6
   AST_EMPTY_BANK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (wins == '0) |-> !deny_now); // R2

endmodule

// File: tb/sim_prot_range_guard.sv
module sim_prot_range_guard;

   localparam int N_WIN  = 6;
   localparam int ADDR_W = 26;
   localparam int CNT_W  = 6;
   localparam int SEL_W  = 3;
   localparam int NV     = 27;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr_en = 1'b0;
   logic [SEL_W-1:0]  reg_wr_sel = '0;
   logic [31:0]       reg_wr_data = '0;
   logic [SEL_W-1:0]  reg_rd_sel = '0;
   logic [31:0]       reg_rd_data;
   logic              freeze = 1'b0;
   logic              acc_valid = 1'b0;
   logic [1:0]        acc_kind = '0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [CNT_W-1:0]  acc_cnt = '0;
   logic              res_valid;
   logic              res_deny;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   prot_range_guard #(.N_WIN(N_WIN), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data), .freeze(freeze),
      .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
      .acc_cnt(acc_cnt), .res_valid(res_valid), .res_deny(res_deny)
   );

   // {req[3:0], expect_deny, kind[1:0], cnt[5:0], addr[25:0]}
   localparam logic [38:0] VECS [NV] = '{
      {4'd3,  1'b1, 2'd0, 6'd0,  26'h0010000}, // R3 first byte
      {4'd3,  1'b1, 2'd0, 6'd0,  26'h0013FFF}, // R3 last byte inclusive
      {4'd3,  1'b0, 2'd0, 6'd0,  26'h0014000}, // R3 one past
      {4'd3,  1'b0, 2'd0, 6'd0,  26'h000FFFF}, // R3 one before
      {4'd6,  1'b1, 2'd0, 6'd7,  26'h000FFFC}, // R6 straddle into window
      {4'd4,  1'b0, 2'd1, 6'd3,  26'h0010000}, // R4 read-only window vs program
      {4'd4,  1'b0, 2'd0, 6'd63, 26'h0020000}, // R4 write-only window vs read
      {4'd4,  1'b1, 2'd1, 6'd63, 26'h0020FC0}, // R4 program to last byte
      {4'd4,  1'b0, 2'd1, 6'd0,  26'h0021000}, // R4 past write window
      {4'd3,  1'b1, 2'd0, 6'd0,  26'h0045000}, // R3 both enables
      {4'd4,  1'b1, 2'd1, 6'd0,  26'h004FFFF}, // R4 both enables
      {4'd5,  1'b0, 2'd0, 6'd0,  26'h0080000}, // R5 no enables, read
      {4'd5,  1'b0, 2'd1, 6'd0,  26'h0081FFF}, // R5 no enables, program
      {4'd8,  1'b0, 2'd0, 6'd0,  26'h00A0000}, // R8 inverted window
      {4'd8,  1'b0, 2'd1, 6'd31, 26'h009FFF0}, // R8 spans both bound pages
      {4'd7,  1'b1, 2'd2, 6'd0,  26'h0020123}, // R7 4K erase block
      {4'd7,  1'b0, 2'd2, 6'd0,  26'h0021FFF}, // R7 4K next block
      {4'd7,  1'b1, 2'd3, 6'd0,  26'h002F000}, // R7 64K block covers window
      {4'd7,  1'b0, 2'd3, 6'd0,  26'h001F000}, // R7 64K over read-only window
      {4'd7,  1'b0, 2'd3, 6'd0,  26'h003FFFF}, // R7 64K empty block
      {4'd7,  1'b1, 2'd2, 6'd0,  26'h004F000}, // R7 4K in both-enable window
      {4'd11, 1'b1, 2'd3, 6'd0,  26'h010ABCD}, // R11 highest index window
      {4'd11, 1'b1, 2'd1, 6'd1,  26'h00FFFFF}, // R11 page carry into window 5
      {4'd4,  1'b0, 2'd0, 6'd0,  26'h0100000}, // R4 read of write-only
      {4'd6,  1'b0, 2'd0, 6'd63, 26'h000FFC0}, // R6 ends just below window
      {4'd6,  1'b1, 2'd0, 6'd63, 26'h000FFC1}, // R6 ends on first byte
      {4'd7,  1'b0, 2'd2, 6'd0,  26'h000FFFF}  // R7 4K just below window
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr_win(input int sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr_en   = 1'b1;
      reg_wr_sel  = SEL_W'(sel);
      reg_wr_data = data;
      @(negedge clk);
      reg_wr_en   = 1'b0;
   endtask

   task automatic rd_win(input int sel, input logic [31:0] exp, input string req);
      reg_rd_sel = SEL_W'(sel);
      #1;
      check(reg_rd_data == exp, req, reg_rd_data, exp);
   endtask

   task automatic access(input logic [1:0] kind, input logic [25:0] addr,
                         input logic [5:0] cnt, input bit exp, input string req);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_kind  = kind;
      acc_addr  = addr;
      acc_cnt   = cnt;
      @(negedge clk);
      acc_valid = 1'b0;
      check(res_valid == 1'b1, req, 32'(res_valid), 32'd1);
      check(res_deny == exp, req, 32'(res_deny), 32'(exp));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset state
      for (int i = 0; i < N_WIN; i++) rd_win(i, 32'h0, "R2");
      check(res_valid == 1'b0, "R2", 32'(res_valid), 32'd0);
      access(2'd0, 26'h0000000, 6'd0, 1'b0, "R2");
      access(2'd3, 26'h3FF0000, 6'd0, 1'b0, "R2");

      // window set
      wr_win(0, 32'h0013_8010); // read-only, pages 010..013
      wr_win(1, 32'h8020_0020); // write-only, page 020
      wr_win(2, 32'h804F_8040); // both, pages 040..04F
      wr_win(3, 32'h0081_0080); // no enables
      wr_win(4, 32'h809F_80A0); // both, inverted
      wr_win(5, 32'h8100_0100); // write-only, page 100
      rd_win(0, 32'h0013_8010, "R1");
      rd_win(4, 32'h809F_80A0, "R1");

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         acc_valid = 1'b1;
         acc_kind  = VECS[v][33:32];
         acc_cnt   = VECS[v][31:26];
         acc_addr  = VECS[v][25:0];
         @(negedge clk);
         acc_valid = 1'b0;
         checks++;
         if (res_valid !== 1'b1 || res_deny !== VECS[v][34]) begin
            errors++;
            $display("FAIL R%0d vector %0d actual=%b%b expected=1%b",
                     VECS[v][38:35], v, res_valid, res_deny, VECS[v][34]);
         end
      end

      // R10: idle cycle after a denied access
      access(2'd0, 26'h0010000, 6'd0, 1'b1, "R10");
      @(negedge clk);
      check(res_valid == 1'b0, "R10", 32'(res_valid), 32'd0);
      check(res_deny == 1'b0, "R10", 32'(res_deny), 32'd0);

      // R9: freeze discards writes
      freeze = 1'b1;
      wr_win(0, 32'h0000_0000);
      rd_win(0, 32'h0013_8010, "R9");
      access(2'd0, 26'h0011000, 6'd0, 1'b1, "R9");
      freeze = 1'b0;

      // R9: out-of-range select discarded
      wr_win(7, 32'hFFFF_FFFF);
      rd_win(7, 32'h0, "R9");
      rd_win(3, 32'h0081_0080, "R9");
      access(2'd0, 26'h0080000, 6'd0, 1'b0, "R9");

      // R1: unstored bits read as zero
      wr_win(3, 32'hFFFF_FFFF);
      rd_win(3, 32'hBFFF_BFFF, "R1");
      access(2'd0, 26'h3FFF000, 6'd0, 1'b1, "R3");
      access(2'd1, 26'h3FFFFFF, 6'd63, 1'b1, "R6");
      access(2'd0, 26'h3FFE000, 6'd0, 1'b0, "R3");

      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule